// File: doc/BRIEF.md
# Fractional TDM Gapped Clock Enable Generator

The block turns a continuous T1 or E1 line clock into a gapped clock qualifier for a downstream cell interface. For each direction it tracks the bit position inside the frame. It asserts a registered enable only in the bit cycles that belong to time slots selected by a 32-bit channel bitmap. The transmit and receive lanes each run on their own line clock, with their own frame sync, format select, clear-channel request and bitmap.

In T1 format a frame has a framing bit followed by 24 eight-bit channels. The framing bit is never enabled. In E1 format a frame has 32 eight-bit time slots. Slot 0 and slot 16 are treated like any other slot, so software gaps them by clearing their select bits. Clear-channel operation opens every bit of an E1 frame and has no effect in T1 format.

The bitmap, the format and the clear-channel request are captured only when a frame starts. Software can rewrite them at any time without creating a partly enabled slot.

Top module: `frac_gap_clk`

## Requirements
- R1: A sync pulse seen at a clock edge makes the next cycle bit 0 of a frame. With no sync, the position advances by one each cycle and wraps after bit 192 in T1 format or after bit 255 in E1 format.
- R2: In T1 format (format select 0), bit position p from 1 to 192 is enabled exactly when bitmap bit (p-1)/8 is set. Bitmap bits 24 to 31 are unused.
- R3: In T1 format, bit 0 (the framing bit) is never enabled, even with an all-ones bitmap and clear-channel requested.
- R4: In E1 format (format select 1) without clear-channel, bit position p is enabled exactly when bitmap bit p/8 is set. This includes slots 0 and 16.
- R5: In E1 format with clear-channel requested (clear input 1), all 256 bit positions are enabled, whatever the bitmap holds.
- R6: In T1 format the clear-channel request is ignored, and the enable follows R2 and R3.
- R7: Bitmap, format and clear-channel inputs are sampled only at the edge that starts bit 0. Changes made within a frame act from the next frame on.
- R8: The transmit and receive lanes are independent. Each uses only its own clock, sync, format, clear and bitmap inputs.
- R9: While reset is low both enables are 0. The first clock edge after release starts bit 0 of a frame, using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Transmit line clock |
| rx_clk_i | input | 1 | Receive line clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_sync_i | input | 1 | Transmit frame sync, one cycle before bit 0 |
| rx_sync_i | input | 1 | Receive frame sync, one cycle before bit 0 |
| tx_e1_i | input | 1 | Transmit format: 0 T1, 1 E1 |
| rx_e1_i | input | 1 | Receive format: 0 T1, 1 E1 |
| tx_clear_i | input | 1 | Transmit clear-channel request (E1 only) |
| rx_clear_i | input | 1 | Receive clear-channel request (E1 only) |
| tx_map_i | input | 32 | Transmit slot select bitmap |
| rx_map_i | input | 32 | Receive slot select bitmap |
| tx_en_o | output | 1 | Transmit gapped clock enable |
| rx_en_o | output | 1 | Receive gapped clock enable |

## Verification
A wrong bit position shows up as the enable edges shifting against the slot boundaries. Because single-slot bitmaps are swept through every slot in both formats, this is seen within one slot time, eight cycles, of the error. A stale or early-loaded shadow bitmap shows as a whole slot opening or closing in the wrong frame when the map is changed mid-frame. A wrong wrap length shows a frame later, as a framing-bit or slot-0 misplacement.

// File: rtl/frac_gap_pkg.sv
package frac_gap_pkg;
  parameter int unsigned BITS_PER_SLOT = 8;
  parameter int unsigned E1_SLOTS      = 32;
  parameter int unsigned T1_CHANNELS   = 24;
  parameter int unsigned T1_OVERHEAD   = 1;

  localparam int unsigned E1_FRAME_LEN = E1_SLOTS * BITS_PER_SLOT;
  localparam int unsigned T1_FRAME_LEN = T1_CHANNELS * BITS_PER_SLOT + T1_OVERHEAD;
  localparam int unsigned POS_W        = $clog2(E1_FRAME_LEN);
  localparam int unsigned MAP_W        = E1_SLOTS;
  localparam int unsigned SLOT_W       = $clog2(E1_SLOTS);
  localparam int unsigned SHIFT        = $clog2(BITS_PER_SLOT);
  localparam int unsigned N_LANES      = 2;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [MAP_W-1:0] map_t;

  typedef enum logic {FMT_T1 = 1'b0, FMT_E1 = 1'b1} fmt_e;

  localparam pos_t T1_LAST = pos_t'(T1_FRAME_LEN - 1);
  localparam pos_t E1_LAST = pos_t'(E1_FRAME_LEN - 1);
endpackage

// File: rtl/fgc_pos_ctr.sv
module fgc_pos_ctr
  import frac_gap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic e1_i,
  output pos_t pos_q_o,
  output pos_t pos_n_o,
  output logic fmt_q_o,
  output logic fmt_n_o,
  output logic start_o
);
  pos_t pos_q, pos_n, last;
  logic fmt_q, fmt_n, start;

  assign last = (fmt_q == FMT_E1) ? E1_LAST : T1_LAST;

  always_comb begin
    if (sync_i)             pos_n = '0;
    else if (pos_q >= last) pos_n = '0;  // reset sentinel also lands here
    else                    pos_n = pos_q + pos_t'(1);
  end

  assign start = (pos_n == '0);
  assign fmt_n = start ? e1_i : fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '1;
      fmt_q <= FMT_T1;
    end else begin
      pos_q <= pos_n;
      fmt_q <= fmt_n;
    end
  end

  assign pos_q_o = pos_q;
  assign pos_n_o = pos_n;
  assign fmt_q_o = fmt_q;
  assign fmt_n_o = fmt_n;
  assign start_o = start;
endmodule

// File: rtl/fgc_map_shadow.sv
module fgc_map_shadow
  import frac_gap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  map_t map_i,
  input  logic clear_i,
  output map_t map_q_o,
  output map_t map_n_o,
  output logic clear_q_o,
  output logic clear_n_o
);
  map_t map_q, map_n;
  logic clear_q, clear_n;

  assign map_n   = load_i ? map_i   : map_q;
  assign clear_n = load_i ? clear_i : clear_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= '0;
      clear_q <= 1'b0;
    end else begin
      map_q   <= map_n;
      clear_q <= clear_n;
    end
  end

  assign map_q_o   = map_q;
  assign map_n_o   = map_n;
  assign clear_q_o = clear_q;
  assign clear_n_o = clear_n;
endmodule

// File: rtl/fgc_slot_decode.sv
module fgc_slot_decode
  import frac_gap_pkg::*;
(
  input  pos_t pos_i,
  input  logic fmt_i,
  input  map_t map_i,
  input  logic clear_i,
  output logic en_o
);
  pos_t              pos_adj;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    // T1 slots start after the overhead bit
    pos_adj = (fmt_i == FMT_E1) ? pos_i : pos_i - pos_t'(T1_OVERHEAD);
    slot    = pos_adj[SHIFT +: SLOT_W];
    if (fmt_i == FMT_E1)
      en_o = clear_i | map_i[slot];
    else if (pos_i < pos_t'(T1_OVERHEAD))
      en_o = 1'b0;
    else
      en_o = map_i[slot];
  end
endmodule

// File: rtl/fgc_lane.sv
module fgc_lane
  import frac_gap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic e1_i,
  input  logic clear_i,
  input  map_t map_i,
  output logic en_o,
  output pos_t pos_o,
  output logic fmt_o,
  output logic clear_o,
  output map_t map_o
);
  pos_t pos_q, pos_n;
  logic fmt_q, fmt_n, start;
  map_t map_q, map_n;
  logic clear_q, clear_n;
  logic en_d, en_q;

  fgc_pos_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .e1_i    (e1_i),
    .pos_q_o (pos_q),
    .pos_n_o (pos_n),
    .fmt_q_o (fmt_q),
    .fmt_n_o (fmt_n),
    .start_o (start)
  );

  fgc_map_shadow u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .map_i     (map_i),
    .clear_i   (clear_i),
    .map_q_o   (map_q),
    .map_n_o   (map_n),
    .clear_q_o (clear_q),
    .clear_n_o (clear_n)
  );

  // Decode next position so the registered enable lines up with its bit.
  fgc_slot_decode u_dec (
    .pos_i   (pos_n),
    .fmt_i   (fmt_n),
    .map_i   (map_n),
    .clear_i (clear_n),
    .en_o    (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o    = en_q;
  assign pos_o   = pos_q;
  assign fmt_o   = fmt_q;
  assign clear_o = clear_q;
  assign map_o   = map_q;
endmodule

// File: rtl/frac_gap_clk.sv
module frac_gap_clk
  import frac_gap_pkg::*;
(
  input  logic        tx_clk_i,
  input  logic        rx_clk_i,
  input  logic        rst_ni,
  input  logic        tx_sync_i,
  input  logic        rx_sync_i,
  input  logic        tx_e1_i,
  input  logic        rx_e1_i,
  input  logic        tx_clear_i,
  input  logic        rx_clear_i,
  input  logic [31:0] tx_map_i,
  input  logic [31:0] rx_map_i,
  output logic        tx_en_o,
  output logic        rx_en_o
);
  // lane 0 = transmit, lane 1 = receive
  logic [N_LANES-1:0]            clk_v, sync_v, e1_v, clear_v, en_v;
  logic [N_LANES-1:0][MAP_W-1:0] map_v;
  logic [N_LANES-1:0][POS_W-1:0] pos_w;
  logic [N_LANES-1:0]            fmt_w, clr_w;
  logic [N_LANES-1:0][MAP_W-1:0] map_w;

  assign clk_v   = {rx_clk_i,   tx_clk_i};
  assign sync_v  = {rx_sync_i,  tx_sync_i};
  assign e1_v    = {rx_e1_i,    tx_e1_i};
  assign clear_v = {rx_clear_i, tx_clear_i};
  assign map_v   = {rx_map_i,   tx_map_i};

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    fgc_lane u_lane (
      .clk_i   (clk_v[g]),
      .rst_ni  (rst_ni),
      .sync_i  (sync_v[g]),
      .e1_i    (e1_v[g]),
      .clear_i (clear_v[g]),
      .map_i   (map_v[g]),
      .en_o    (en_v[g]),
      .pos_o   (pos_w[g]),
      .fmt_o   (fmt_w[g]),
      .clear_o (clr_w[g]),
      .map_o   (map_w[g])
    );
  end

  assign tx_en_o = en_v[0];
  assign rx_en_o = en_v[1];
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker
  import frac_gap_pkg::*;
(
  input logic                            tx_clk_i,
  input logic                            rx_clk_i,
  input logic                            rst_ni,
  input logic                            tx_sync_i,
  input logic                            rx_sync_i,
  input logic                            tx_en_o,
  input logic                            rx_en_o,
  input logic [N_LANES-1:0][POS_W-1:0]   pos_w,
  input logic [N_LANES-1:0]              fmt_w,
  input logic [N_LANES-1:0]              clr_w,
  input logic [N_LANES-1:0][MAP_W-1:0]   map_w
);
  logic [N_LANES-1:0] clk_v, sync_v, en_v;
  assign clk_v  = {rx_clk_i, tx_clk_i};
  assign sync_v = {rx_sync_i, tx_sync_i};
  assign en_v   = {rx_en_o, tx_en_o};

  for (genvar g = 0; g < N_LANES; g++) begin : g_chk
    // R1: sync forces bit 0 next cycle
    a_r1_sync_zero: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      sync_v[g] |=> pos_w[g] == '0);
    // R1: wrap at frame end
    a_r1_wrap: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      (!sync_v[g] && pos_w[g] == (fmt_w[g] ? E1_LAST : T1_LAST)) |=> pos_w[g] == '0);
    // R1: plain advance
    a_r1_step: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      (!sync_v[g] && pos_w[g] < (fmt_w[g] ? E1_LAST : T1_LAST))
        |=> pos_w[g] == $past(pos_w[g]) + pos_t'(1));
    // R3: framing bit gapped
    a_r3_fbit_gapped: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      (!fmt_w[g] && pos_w[g] == '0) |-> !en_v[g]);
    // R4: E1 slot follows shadow map
    a_r4_e1_slot: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      (fmt_w[g] && !clr_w[g]) |-> en_v[g] == map_w[g][pos_w[g][POS_W-1 -: SLOT_W]]);
    // R5: clear-channel opens every E1 bit
    a_r5_clear_open: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      (fmt_w[g] && clr_w[g]) |-> en_v[g]);
    // R7: shadow only changes at frame start
    a_r7_map_hold: assert property (@(posedge clk_v[g]) disable iff (!rst_ni)
      pos_w[g] != '0 |-> ($stable(map_w[g]) && $stable(fmt_w[g]) && $stable(clr_w[g])));
  end
endmodule

bind frac_gap_clk fgc_checker u_chk (
  .tx_clk_i  (tx_clk_i),
  .rx_clk_i  (rx_clk_i),
  .rst_ni    (rst_ni),
  .tx_sync_i (tx_sync_i),
  .rx_sync_i (rx_sync_i),
  .tx_en_o   (tx_en_o),
  .rx_en_o   (rx_en_o),
  .pos_w     (pos_w),
  .fmt_w     (fmt_w),
  .clr_w     (clr_w),
  .map_w     (map_w)
);

// File: tb/sim_frac_gap_clk.sv
module sim_frac_gap_clk;
  logic clk = 1'b0;
  logic rst_ni;
  logic [1:0] b_sync, b_e1, b_clr;
  logic [31:0] b_map [2];
  logic tx_en, rx_en;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "";

  int          m_pos [2];
  bit          m_e1  [2];
  bit          m_clr [2];
  logic [31:0] m_map [2];
  bit          m_exp [2];

  always #5 clk = ~clk;

  frac_gap_clk u0 (
    .tx_clk_i  (clk),
    .rx_clk_i  (clk),
    .rst_ni    (rst_ni),
    .tx_sync_i (b_sync[0]),
    .rx_sync_i (b_sync[1]),
    .tx_e1_i   (b_e1[0]),
    .rx_e1_i   (b_e1[1]),
    .tx_clear_i(b_clr[0]),
    .rx_clear_i(b_clr[1]),
    .tx_map_i  (b_map[0]),
    .rx_map_i  (b_map[1]),
    .tx_en_o   (tx_en),
    .rx_en_o   (rx_en)
  );

  function automatic bit want(int p, bit e1, logic [31:0] m, bit c);
    if (e1) return c ? 1'b1 : m[p / 8];
    if (p == 0) return 1'b0;
    return m[(p - 1) / 8];
  endfunction

  function automatic string tag(int p, bit e1, bit c);
    if (phase != "") return phase;
    if (!e1 && p == 0) return "R3";
    if (!e1 && c) return "R6";
    if (!e1) return "R2";
    if (c) return "R5";
    return "R4";
  endfunction

  task automatic check(string req, bit got, bit exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  // inputs are set; advance one edge and compare at the following negedge
  task automatic tick();
    for (int d = 0; d < 2; d++) begin
      int np;
      if (b_sync[d]) np = 0;
      else if (m_pos[d] >= (m_e1[d] ? 255 : 192)) np = 0;
      else np = m_pos[d] + 1;
      if (np == 0) begin
        m_e1[d] = b_e1[d]; m_map[d] = b_map[d]; m_clr[d] = b_clr[d];
      end
      m_pos[d] = np;
      m_exp[d] = want(np, m_e1[d], m_map[d], m_clr[d]);
    end
    @(negedge clk);
    check(tag(m_pos[0], m_e1[0], m_clr[0]), tx_en, m_exp[0], $sformatf("tx pos=%0d", m_pos[0]));
    check(tag(m_pos[1], m_e1[1], m_clr[1]), rx_en, m_exp[1], $sformatf("rx pos=%0d", m_pos[1]));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_sync(logic [1:0] which);
    b_sync = which;
    tick();
    b_sync = 2'b00;
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst_ni = 1'b0;
    b_sync = '0; b_e1 = '0; b_clr = '0;
    b_map[0] = 32'h00A5_0F81; b_map[1] = 32'h005A_F07E;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", tx_en, 1'b0, "tx in reset");
      check("R9", rx_en, 1'b0, "rx in reset");
    end
    for (int d = 0; d < 2; d++) begin
      m_pos[d] = 255; m_e1[d] = 0; m_clr[d] = 0; m_map[d] = '0;
    end
    rst_ni = 1'b1;
    phase = "R9";
    tick();
    phase = "";
    // T1 free-running over two wraps, lanes with complementary maps (R2, R3, R8)
    run(400);
    // sync on tx only, mid-frame (R1, R8)
    phase = "R1";
    run(37);
    pulse_sync(2'b01);
    run(250);
    pulse_sync(2'b10);
    run(250);
    pulse_sync(2'b11);
    run(200);
    phase = "";
    // T1 with clear request and all-ones map (R3, R6)
    b_clr = 2'b11; b_map[0] = '1; b_map[1] = 32'h0080_0001;
    run(420);
    b_clr = 2'b00;
    // single-slot sweep in both formats (R2, R3, R4)
    for (int f = 0; f < 2; f++) begin
      b_e1 = {f[0], f[0]};
      for (int s = 0; s < 32; s++) begin
        b_map[0] = 32'h1 << s;
        b_map[1] = ~(32'h1 << s);
        pulse_sync(2'b11);
        run(f == 1 ? 256 : 193);
      end
    end
    // E1 with TS0/TS16 deselected on tx, selected on rx (R4)
    b_map[0] = 32'hFFFE_FFFE; b_map[1] = 32'h0001_0001;
    run(600);
    // E1 clear-channel on tx, empty map on rx (R5, R4)
    b_clr = 2'b01; b_map[0] = '0; b_map[1] = '0;
    run(560);
    b_clr = 2'b00;
    // mid-frame churn of map, format and clear (R7)
    phase = "R7";
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      b_map[0] = lf; b_map[1] = ~lf ^ 32'h0F0F_0000;
      if (i % 97 == 0) b_e1 = lf[9:8];
      if (i % 61 == 0) b_clr = lf[3:2];
      tick();
    end
    phase = "";
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule